// File: doc/BRIEF.md
# Centre-Aligned Dual-Slope PWM Timer

This block is a 16-bit timer whose counter climbs from zero to a programmable ceiling and then falls back to zero, over and over. Two compare channels watch the counter. Each channel drives one PWM pin whose edges sit symmetrically about the turning point at the ceiling, so the pulses are centre-aligned.

A prescaler divides the system clock into a tick enable. Every register runs on the system clock, and the counter moves only on ticks. Software writes the ceiling and the compare values into shadow registers. The block copies them into the live registers only when the counter sits at zero, so every period stays symmetric.

Each channel has a two-bit output mode that selects disconnected, non-inverted or inverted output. Each channel also has a match flag that software can clear.

Top module: `centre_pwm_timer`

## Requirements
- R1: After reset, both PWM pins and both flags are 0. The counter is at zero and counting up. The prescaler select is 0 (stopped). Until a select is written, no output or flag changes.
- R2: The prescaler select `psc_wdata` encodes the divide ratio: 1 gives /1, 2 gives /8, 3 gives /64, 4 gives /256 and 5 gives /1024. Values 0, 6 and 7 stop the tick, and the counter, outputs and flags then freeze. Writing the select restarts the divider phase.
- R3: The counter steps 0, 1, …, TOP, TOP−1, …, 1, 0, … with no dwell at either end. A PWM period is therefore 2 × N × TOP system clocks, where N is the divide ratio.
- R4: In mode 2 (non-inverted), a match while the counter is rising clears the pin, and a match while it is falling sets it. A match at TOP counts as falling, and a match at zero counts as rising. With compare value C, the pin is high for 2 × N × C clocks of each period.
- R5: Mode 3 (inverted) drives each pin to the complement of the level that mode 2 would give.
- R6: Modes 0 and 1 drive the pin low.
- R7: In mode 2, a compare value of 0 holds the pin low and a compare value equal to TOP holds it high, period after period.
- R8: Writes to TOP and to the compare values land in shadow registers. They are copied to the live registers only on the tick at which the counter equals zero. Until that tick, the waveform follows the old values.
- R9: A channel's flag goes to 1 one system clock after a tick on which the counter equals that channel's live compare value.
- R10: A 1 on `flag_clr[i]` clears flag i on the next edge. If a match occurs on the same edge, the flag is set instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| top_wr | input | 1 | Write strobe for the TOP shadow register |
| top_wdata | input | 16 | TOP value to write |
| cmp_wr | input | 2 | Per-channel write strobe for the compare shadow register |
| cmp_wdata | input | 16 | Compare value to write (shared by both channels) |
| psc_wr | input | 1 | Write strobe for the prescaler select |
| psc_wdata | input | 3 | Prescaler select code |
| mode_wr | input | 1 | Write strobe for both channels' output modes |
| mode_wdata | input | 4 | Output modes: bits [1:0] for channel 0, bits [3:2] for channel 1 |
| flag_clr | input | 2 | Per-channel flag clear strobe |
| pwm_out | output | 2 | PWM pins |
| match_flag | output | 2 | Per-channel compare-match flags |

## Verification
Two events can land on the same edge. The compare match that sets a flag can coincide with a software clear of that flag. The shadow-to-live copy at zero can also coincide with a match evaluated against the outgoing compare value.

To provoke the first case, the bench holds a clear strobe high across whole periods at /1, so a clear is present on every match edge. Set-wins is then judged by counting exactly two single-clock flag pulses per period. To provoke the second case, the bench rewrites compare values in mid-period and at zero compare values. A behavioural model, compared on every clock, decides which value each match used.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int CNT_W = 16;
    localparam int DIV_W = 10;
    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        CM_OFF    = 2'd0,
        CM_RSVD   = 2'd1,
        CM_NONINV = 2'd2,
        CM_INV    = 2'd3
    } cmp_mode_e;

    typedef enum logic {
        SLOPE_UP   = 1'b0,
        SLOPE_DOWN = 1'b1
    } slope_e;

    typedef struct packed {
        logic             tick;
        logic             at_bottom;
        slope_e           slope;
        logic [CNT_W-1:0] cnt;
    } timer_state_t;

    function automatic logic psc_running(input logic [SEL_W-1:0] sel);
        return (sel >= 3'd1) && (sel <= 3'd5);
    endfunction

    // Terminal value of the divider phase counter (ratio - 1).
    function automatic logic [DIV_W-1:0] psc_limit(input logic [SEL_W-1:0] sel);
        logic [DIV_W-1:0] lim;
        case (sel)
            3'd2:    lim = DIV_W'(7);
            3'd3:    lim = DIV_W'(63);
            3'd4:    lim = DIV_W'(255);
            3'd5:    lim = DIV_W'(1023);
            default: lim = '0;
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    output logic             tick
);

    logic [SEL_W-1:0] sel_q;
    logic [DIV_W-1:0] div_q;

    assign tick = psc_running(sel_q) && (div_q == psc_limit(sel_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            div_q <= '0;
        end else if (sel_wr) begin
            sel_q <= sel_wdata;
            div_q <= '0;
        end else if (psc_running(sel_q)) begin
            div_q <= tick ? '0 : div_q + 1'b1;
        end
    end

    // R2: a stopped select yields no tick on the following cycle
    assert_stop_freezes_R2: assert property (@(posedge clk) disable iff (rst)
        (!psc_running(sel_q) && !sel_wr) |=> !tick);

    // R2: divided ratios never tick on back-to-back cycles
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !sel_wr && psc_limit(sel_q) != '0) |=> !tick);

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             top_wr,
    input  logic [CNT_W-1:0] top_wdata,
    output timer_state_t     st,
    output logic             load
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_buf_q;
    logic [CNT_W-1:0] top_act_q;
    slope_e           dir_q;
    logic             at_bottom;
    logic             at_peak;

    assign at_bottom = (cnt_q == '0);
    assign at_peak   = (dir_q == SLOPE_UP) && !at_bottom && (cnt_q >= top_act_q);
    assign load      = tick && at_bottom;

    always_comb begin
        st.tick      = tick;
        st.at_bottom = at_bottom;
        st.cnt       = cnt_q;
        if (at_bottom)    st.slope = SLOPE_UP;
        else if (at_peak) st.slope = SLOPE_DOWN;
        else              st.slope = dir_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            top_buf_q <= '0;
            top_act_q <= '0;
            dir_q     <= SLOPE_UP;
        end else begin
            if (top_wr) top_buf_q <= top_wdata;
            if (tick) begin
                if (at_bottom) begin
                    top_act_q <= top_buf_q;
                    cnt_q     <= (top_buf_q == '0) ? '0 : CNT_W'(1);
                    dir_q     <= SLOPE_UP;
                end else if (at_peak) begin
                    cnt_q <= cnt_q - 1'b1;
                    dir_q <= SLOPE_DOWN;
                end else if (dir_q == SLOPE_UP) begin
                    cnt_q <= cnt_q + 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    // R3: the counter never leaves the range [0, live TOP]
    assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= top_act_q);

    // R8: live TOP moves only at the bottom update point
    assert_top_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(top_act_q));

endmodule

// File: rtl/pwm_compare_channel.sv
module pwm_compare_channel
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  timer_state_t     st,
    input  logic             load,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             mode_wr,
    input  logic [1:0]       mode_wdata,
    input  logic             flag_clr,
    output logic             pwm,
    output logic             flag
);

    logic [CNT_W-1:0] cmp_buf_q;
    logic [CNT_W-1:0] cmp_act_q;
    cmp_mode_e        mode_q;
    logic             wave_q;   // non-inverted waveform level
    logic             flag_q;
    logic             match;

    assign match = st.tick && (st.cnt == cmp_act_q);
    assign flag  = flag_q;

    always_comb begin
        case (mode_q)
            CM_NONINV: pwm = wave_q;
            CM_INV:    pwm = ~wave_q;
            default:   pwm = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_buf_q <= '0;
            cmp_act_q <= '0;
            mode_q    <= CM_OFF;
            wave_q    <= 1'b0;
            flag_q    <= 1'b0;
        end else begin
            if (cmp_wr)  cmp_buf_q <= cmp_wdata;
            if (load)    cmp_act_q <= cmp_buf_q;
            if (mode_wr) mode_q    <= cmp_mode_e'(mode_wdata);
            if (match)   wave_q    <= (st.slope == SLOPE_DOWN);
            if (match)         flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    // R10: a match beats a simultaneous clear
    assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (rst)
        match |=> flag_q);

    // R9: a flag only rises after a timer tick
    assert_flag_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(st.tick));

    // R4: rising-slope match drives a non-inverted pin low
    assert_up_match_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (match && st.slope == SLOPE_UP && mode_q == CM_NONINV && !mode_wr) |=> !pwm);

    // R8: live compare value moves only at the bottom update point
    assert_cmp_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cmp_act_q));

endmodule

// File: rtl/centre_pwm_timer.sv
module centre_pwm_timer
    import pwm_pkg::*;
#(
    parameter int N_CH = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                top_wr,
    input  logic [CNT_W-1:0]    top_wdata,
    input  logic [N_CH-1:0]     cmp_wr,
    input  logic [CNT_W-1:0]    cmp_wdata,
    input  logic                psc_wr,
    input  logic [SEL_W-1:0]    psc_wdata,
    input  logic                mode_wr,
    input  logic [2*N_CH-1:0]   mode_wdata,
    input  logic [N_CH-1:0]     flag_clr,
    output logic [N_CH-1:0]     pwm_out,
    output logic [N_CH-1:0]     match_flag
);

    logic         tick;
    logic         load;
    timer_state_t st;

    pwm_prescaler u_prescaler (
        .clk       (clk),
        .rst       (rst),
        .sel_wr    (psc_wr),
        .sel_wdata (psc_wdata),
        .tick      (tick)
    );

    pwm_updown_counter u_counter (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .top_wr    (top_wr),
        .top_wdata (top_wdata),
        .st        (st),
        .load      (load)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        pwm_compare_channel u_ch (
            .clk        (clk),
            .rst        (rst),
            .st         (st),
            .load       (load),
            .cmp_wr     (cmp_wr[i]),
            .cmp_wdata  (cmp_wdata),
            .mode_wr    (mode_wr),
            .mode_wdata (mode_wdata[2*i +: 2]),
            .flag_clr   (flag_clr[i]),
            .pwm        (pwm_out[i]),
            .flag       (match_flag[i])
        );
    end

    // R1: with the prescaler never started, pins stay quiet
    assert_quiet_when_stopped_R1: assert property (@(posedge clk) disable iff (rst)
        (!tick && $past(!tick) && !mode_wr && $past(!mode_wr)) |-> $stable(pwm_out));

endmodule

// File: tb/centre_pwm_timer_bench.sv
module centre_pwm_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        top_wr = 1'b0;
    logic [15:0] top_wdata = '0;
    logic [1:0]  cmp_wr = '0;
    logic [15:0] cmp_wdata = '0;
    logic        psc_wr = 1'b0;
    logic [2:0]  psc_wdata = '0;
    logic        mode_wr = 1'b0;
    logic [3:0]  mode_wdata = '0;
    logic [1:0]  flag_clr = '0;
    logic [1:0]  pwm_out;
    logic [1:0]  match_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    centre_pwm_timer u_centre_pwm_timer (
        .clk(clk), .rst(rst),
        .top_wr(top_wr), .top_wdata(top_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .psc_wr(psc_wr), .psc_wdata(psc_wdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .flag_clr(flag_clr),
        .pwm_out(pwm_out), .match_flag(match_flag)
    );

    // ---------------- behavioural reference model ----------------
    int m_sel, m_phase, m_cnt, m_rising;
    int m_top_sh, m_top_live;
    int m_cmp_sh[2], m_cmp_live[2], m_mode[2];
    bit m_lvl[2], m_flg[2];

    function automatic int ratio_of(int s);
        case (s)
            1: return 1;
            2: return 8;
            3: return 64;
            4: return 256;
            5: return 1024;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_pin(int ch);
        if (m_mode[ch] == 2) return m_lvl[ch];
        if (m_mode[ch] == 3) return !m_lvl[ch];
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sel = 0; m_phase = 0; m_cnt = 0; m_rising = 1;
            m_top_sh = 0; m_top_live = 0;
            for (int c = 0; c < 2; c++) begin
                m_cmp_sh[c] = 0; m_cmp_live[c] = 0; m_mode[c] = 0;
                m_lvl[c] = 0; m_flg[c] = 0;
            end
        end else begin
            bit tk, falling, turn;
            bit hit[2];
            tk = ratio_of(m_sel) != 0 && m_phase == ratio_of(m_sel) - 1;
            hit[0] = 0; hit[1] = 0;
            if (tk) begin
                turn    = m_rising && m_cnt != 0 && m_cnt >= m_top_live;
                falling = m_cnt != 0 && (turn || !m_rising);
                for (int c = 0; c < 2; c++)
                    if (m_cnt == m_cmp_live[c]) begin
                        hit[c] = 1;
                        m_lvl[c] = falling;
                    end
                if (m_cnt == 0) begin
                    m_top_live = m_top_sh;
                    for (int c = 0; c < 2; c++) m_cmp_live[c] = m_cmp_sh[c];
                    m_cnt = (m_top_live == 0) ? 0 : 1;
                    m_rising = 1;
                end else if (turn) begin
                    m_cnt = m_cnt - 1; m_rising = 0;
                end else begin
                    m_cnt = m_rising ? m_cnt + 1 : m_cnt - 1;
                end
            end
            if (psc_wr) begin
                m_sel = psc_wdata; m_phase = 0;
            end else if (ratio_of(m_sel) != 0) begin
                m_phase = tk ? 0 : m_phase + 1;
            end
            if (top_wr) m_top_sh = top_wdata;
            for (int c = 0; c < 2; c++) begin
                if (cmp_wr[c]) m_cmp_sh[c] = cmp_wdata;
                if (mode_wr) m_mode[c] = mode_wdata[2*c +: 2];
                if (hit[c]) m_flg[c] = 1;
                else if (flag_clr[c]) m_flg[c] = 0;
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            for (int c = 0; c < 2; c++) begin
                checks++;
                if (pwm_out[c] !== exp_pin(c)) begin
                    errors++;
                    $display("FAIL R4/R5/R8 model pin ch%0d at %0t: actual %b expected %b",
                             c, $time, pwm_out[c], exp_pin(c));
                end
                checks++;
                if (match_flag[c] !== m_flg[c]) begin
                    errors++;
                    $display("FAIL R9/R10 model flag ch%0d at %0t: actual %b expected %b",
                             c, $time, match_flag[c], m_flg[c]);
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_top(input int v);
        @(negedge clk); top_wr = 1; top_wdata = 16'(v);
        @(negedge clk); top_wr = 0;
    endtask

    task automatic set_cmp(input int ch, input int v);
        @(negedge clk); cmp_wr = 2'b01 << ch; cmp_wdata = 16'(v);
        @(negedge clk); cmp_wr = 0;
    endtask

    task automatic set_modes(input int m0, input int m1);
        @(negedge clk); mode_wr = 1; mode_wdata = {2'(m1), 2'(m0)};
        @(negedge clk); mode_wr = 0;
    endtask

    task automatic set_psc(input int s);
        @(negedge clk); psc_wr = 1; psc_wdata = 3'(s);
        @(negedge clk); psc_wr = 0;
    endtask

    // period and high time between two rising edges of a pin
    task automatic measure(input int ch, output int per, output int hi);
        bit prev, cur;
        cur = pwm_out[ch];
        do begin @(negedge clk); prev = cur; cur = pwm_out[ch]; end while (!(!prev && cur));
        per = 1; hi = 1;
        forever begin
            @(negedge clk); prev = cur; cur = pwm_out[ch];
            if (!prev && cur) break;
            per++;
            if (cur) hi++;
        end
    endtask

    task automatic count_high(input int ch, input int n, input bit flags, output int hi);
        hi = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (flags ? match_flag[ch] : pwm_out[ch]) hi++;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int per, hi, cnt;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state and idle without a prescaler write
        @(negedge clk);
        check(pwm_out == 2'b00, "R1 pins after reset", pwm_out, 0);
        check(match_flag == 2'b00, "R1 flags after reset", match_flag, 0);
        set_top(10); set_cmp(0, 4); set_cmp(1, 4); set_modes(2, 3);
        count_high(1, 30, 1'b0, cnt);
        check(cnt == 30, "R1 inverted pin idle while stopped", cnt, 30);
        check(match_flag == 2'b00, "R1 flags idle while stopped", match_flag, 0);

        // R3 R4 R5: /1, TOP=10, compare 4
        set_psc(1);
        measure(0, per, hi);
        measure(0, per, hi);
        check(per == 20, "R3 period /1 TOP10", per, 20);
        check(hi == 8, "R4 high time C4", hi, 8);
        measure(1, per, hi);
        check(per - hi == 8, "R5 inverted low time", per - hi, 8);
        check(pwm_out[1] == !pwm_out[0], "R5 complementary pins", pwm_out[1], !pwm_out[0]);

        // R10: clear held across matches, set must win
        @(negedge clk); flag_clr = 2'b01;
        count_high(0, 40, 1'b1, cnt);
        check(cnt == 4, "R10 set beats clear, pulses in 2 periods", cnt, 4);
        @(negedge clk); flag_clr = 2'b00;
        // R9: flag stays set without a clear until cleared
        count_high(0, 5, 1'b1, cnt);
        @(negedge clk); flag_clr = 2'b11;
        @(negedge clk); flag_clr = 2'b00;

        // R8: mid-period compare rewrite, follows at next bottom
        repeat (7) @(negedge clk);
        set_cmp(0, 7);
        measure(0, per, hi);
        measure(0, per, hi);
        check(hi == 14, "R8 new compare after bottom", hi, 14);
        set_top(12);
        measure(0, per, hi);
        measure(0, per, hi);
        check(per == 24, "R8 new TOP after bottom", per, 24);

        // R7: compare extremes
        set_top(10); set_cmp(0, 0); set_cmp(1, 10); set_modes(2, 2);
        repeat (60) @(negedge clk);
        count_high(0, 40, 1'b0, cnt);
        check(cnt == 0, "R7 compare zero stays low", cnt, 0);
        count_high(1, 40, 1'b0, cnt);
        check(cnt == 40, "R7 compare TOP stays high", cnt, 40);

        // R6: disconnected and reserved modes
        set_cmp(0, 4); set_cmp(1, 4);
        set_modes(0, 1);
        count_high(0, 40, 1'b0, cnt);
        check(cnt == 0, "R6 mode 0 low", cnt, 0);
        count_high(1, 40, 1'b0, cnt);
        check(cnt == 0, "R6 mode 1 low", cnt, 0);

        // R2 R3: every divide ratio, TOP=2, compare 1
        set_modes(2, 2); set_top(2); set_cmp(0, 1); set_cmp(1, 1);
        for (int s = 1; s <= 5; s++) begin
            set_psc(s);
            measure(0, per, hi);
            measure(0, per, hi);
            check(per == 4 * ratio_of(s), "R2 R3 period per ratio", per, 4 * ratio_of(s));
            check(hi == 2 * ratio_of(s), "R2 R4 high per ratio", hi, 2 * ratio_of(s));
        end

        // R2: stopping freezes everything
        set_psc(1);
        repeat (9) @(negedge clk);
        set_psc(6);
        begin
            logic [1:0] p0, f0;
            p0 = pwm_out; f0 = match_flag;
            repeat (20) @(negedge clk);
            check(pwm_out == p0, "R2 select 6 freezes pins", pwm_out, p0);
            check(match_flag == f0, "R2 select 6 freezes flags", match_flag, f0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule